// File: doc/BRIEF.md
# Buffered Start-Stop Serial Transmitter

This block turns bytes written into a sixteen-entry first-in first-out store into asynchronous start-stop frames on a single serial line. Software or a DMA engine pushes bytes with a one-cycle write strobe. The block reports how many bytes are waiting and raises a level request whenever the store is empty, so the producer can refill it. An external baud tick, one clock cycle wide and issued once per bit period, sets the bit timing.

Four static inputs select the frame format: 7 or 8 data bits, parity off, even or odd, and one or two stop bits. The format is captured when a frame is launched. An active-low clear-to-send input is consulted only when a new frame could start, so a frame that has begun always runs to its end. A write that arrives while the store is full is dropped and sets a sticky overflow flag, which only reset clears.

The sequencer has five states. IDLE holds the line high. START drives the low start bit. DATA shifts out the data bits. PARITY sends the parity bit. STOP holds the line high for the stop period. These are the transitions:
- launch: IDLE goes to START on a tick when data is waiting and clear-to-send is low.
- start_done: START goes to DATA on the next tick.
- data_done: DATA goes to PARITY, or straight to STOP when parity is off, on the tick after the last data bit.
- parity_done: PARITY goes to STOP on a tick.
- chain: STOP goes directly to START on the tick that ends the stop period, if a launch is allowed then.
- finish: STOP goes to IDLE on that same tick when no launch is allowed.

Top module: `fifo_uart_tx`

## Requirements
- R1: After reset, txd is 1, fill_count is 0, drain_req is 1 and overflow is 0. The line stays at 1 whenever no frame is being sent.
- R2: Each frame begins with one 0 start bit, followed by the data bits least significant bit first. Every bit lasts exactly one baud tick period, and txd changes only on a clock edge where baud_tick is 1.
- R3: With fmt_eight=1, all 8 bits of the byte are sent. With fmt_eight=0, only bits 6:0 are sent and bit 7 of the written byte is ignored.
- R4: With fmt_par_en=1, one parity bit follows the data. For even parity (fmt_par_odd=0) it is the XOR of the sent data bits. For odd parity (fmt_par_odd=1) it is the inverse of that XOR. With fmt_par_en=0, no parity bit is sent.
- R5: The frame ends with one stop bit at 1 when fmt_two_stop=0, and with two stop bits at 1 when fmt_two_stop=1.
- R6: A frame is launched only on a tick where cts_n is 0. Raising cts_n during a frame does not cut that frame short, but it holds back the following one.
- R7: fill_count equals the number of accepted bytes not yet taken for sending, and drain_req is 1 exactly when fill_count is 0.
- R8: A write while fill_count equals 16 is discarded and sets overflow, which stays 1 until reset.
- R9: When data is waiting and cts_n is 0, the next start bit immediately follows the last stop bit, with no idle bit period between frames.
- R10: Bytes are sent in the order they were accepted, and each accepted byte is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe that writes wr_data into the store |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One-cycle pulse marking each bit period |
| cts_n | input | 1 | Active-low clear-to-send, checked only when a frame could be launched |
| fmt_eight | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| fmt_par_en | input | 1 | 1 adds a parity bit |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| fmt_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| txd | output | 1 | Serial line, high when idle |
| fill_count | output | 5 | Number of bytes waiting |
| drain_req | output | 1 | High while the store is empty |
| overflow | output | 1 | Sticky flag set by a write to a full store |

## Verification
The bench sends bytes under six frame formats. It uses all-ones, all-zeros, alternating and single-bit bytes, so that bit order, the 7-bit truncation and the even/odd parity sense give different results. A burst that preloads the full store while clear-to-send is held off, then releases it, tests back-to-back chaining with no idle gap, ordering, and the dropping of the seventeenth write. A separate pattern raises clear-to-send during a frame, to show that the frame in progress completes while the next one is held.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } ftx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } ftx_fmt_t;

    function automatic logic ftx_parity(input logic [7:0] d, input ftx_fmt_t f);
        logic [7:0] m;
        m = f.eight ? d : {1'b0, d[6:0]};
        return (^m) ^ f.par_odd;
    endfunction

endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic [CW-1:0]    count,
    output logic             ovf
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q;
    logic             ovf_q;
    logic             full, push_ok, pop_ok;

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = count_q;
    assign ovf     = ovf_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
            if (push && full) ovf_q <= 1'b1;
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    a_r8_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count_q == CW'(DEPTH)));

endmodule

// File: rtl/ftx_framer.sv
module ftx_framer
    import ftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       cts_n,
    input  ftx_fmt_t   fmt,
    input  logic       src_empty,
    input  logic [7:0] src_data,
    output logic       pop,
    output logic       txd
);
    ftx_state_e state_q, state_d;
    logic [7:0] shift_q, shift_d;
    logic [2:0] bit_q, bit_d;
    logic       stop_q, stop_d;
    logic       par_q, par_d;
    ftx_fmt_t   fmt_q, fmt_d;
    logic       launch, load;
    logic [2:0] last_bit;

    assign launch   = baud_tick && !src_empty && !cts_n;
    assign last_bit = fmt_q.eight ? 3'd7 : 3'd6;

    always_comb begin
        state_d = state_q;
        shift_d = shift_q;
        bit_d   = bit_q;
        stop_d  = stop_q;
        par_d   = par_q;
        fmt_d   = fmt_q;
        load    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (launch) load = 1'b1;
            end
            S_START: begin
                if (baud_tick) begin
                    state_d = S_DATA;
                    bit_d   = 3'd0;
                end
            end
            S_DATA: begin
                if (baud_tick) begin
                    shift_d = {1'b0, shift_q[7:1]};
                    if (bit_q == last_bit) begin
                        state_d = fmt_q.par_en ? S_PARITY : S_STOP;
                        stop_d  = 1'b0;
                    end else begin
                        bit_d = bit_q + 3'd1;
                    end
                end
            end
            S_PARITY: begin
                if (baud_tick) begin
                    state_d = S_STOP;
                    stop_d  = 1'b0;
                end
            end
            S_STOP: begin
                if (baud_tick) begin
                    if (stop_q == fmt_q.two_stop) begin
                        if (launch) load = 1'b1;
                        else        state_d = S_IDLE;
                    end else begin
                        stop_d = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (load) begin
            state_d = S_START;
            shift_d = src_data;
            fmt_d   = fmt;
            par_d   = ftx_parity(src_data, fmt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            shift_q <= '0;
            bit_q   <= '0;
            stop_q  <= 1'b0;
            par_q   <= 1'b0;
            fmt_q   <= '0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            bit_q   <= bit_d;
            stop_q  <= stop_d;
            par_q   <= par_d;
            fmt_q   <= fmt_d;
        end
    end

    always_comb begin
        pop = load;
        unique case (state_q)
            S_START:  txd = 1'b0;
            S_DATA:   txd = shift_q[0];
            S_PARITY: txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> txd);
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));
    a_r6_cts_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && $past(state_q) != S_START) |-> $past(!cts_n));
    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP) |-> txd);

endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          baud_tick,
    input  logic          cts_n,
    input  logic          fmt_eight,
    input  logic          fmt_par_en,
    input  logic          fmt_par_odd,
    input  logic          fmt_two_stop,
    output logic          txd,
    output logic [CW-1:0] fill_count,
    output logic          drain_req,
    output logic          overflow
);
    import ftx_pkg::*;

    ftx_fmt_t   fmt;
    logic       pop, empty;
    logic [7:0] head;

    assign fmt       = '{eight: fmt_eight, par_en: fmt_par_en,
                         par_odd: fmt_par_odd, two_stop: fmt_two_stop};
    assign drain_req = empty;

    ftx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .count     (fill_count),
        .ovf       (overflow)
    );

    ftx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .cts_n     (cts_n),
        .fmt       (fmt),
        .src_empty (empty),
        .src_data  (head),
        .pop       (pop),
        .txd       (txd)
    );

    a_r7_drain_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req == (fill_count == '0));

endmodule

// File: tb/fifo_uart_tx_bench.sv
module fifo_uart_tx_bench;
    localparam int TICKP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       cts_n = 1'b0;
    logic       fmt_eight = 1'b1, fmt_par_en = 1'b0, fmt_par_odd = 1'b0, fmt_two_stop = 1'b0;
    logic       txd;
    logic [4:0] fill_count;
    logic       drain_req, overflow;

    always #5 clk = ~clk;

    fifo_uart_tx u_fifo_uart_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .cts_n(cts_n), .fmt_eight(fmt_eight),
        .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd), .fmt_two_stop(fmt_two_stop),
        .txd(txd), .fill_count(fill_count), .drain_req(drain_req), .overflow(overflow)
    );

    typedef struct {
        logic [7:0] d;
        logic eight, pen, podd, two;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, frames = 0;
    bit gap_check_en = 0, done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (TICKP - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic get_bit(output logic b);
        do @(negedge clk); while (baud_tick !== 1'b1);
        b = txd;
    endtask

    // monitor: decodes frames, pops the scoreboard and compares
    initial begin
        logic b;
        logic [7:0] got, mask;
        int idle_cnt, n;
        bit more_prev;
        exp_t e;
        idle_cnt = 100;
        more_prev = 0;
        @(posedge rst_n);
        forever begin
            get_bit(b);
            if (b) idle_cnt++;
            else if (q.size() == 0) begin
                check(0, "R10 frame with nothing queued", 1, 0);
            end else begin
                e = q.pop_front();
                if (gap_check_en && more_prev)
                    check(idle_cnt == 0, "R9 idle gap between frames", idle_cnt, 0);
                n = e.eight ? 8 : 7;
                mask = e.eight ? 8'hFF : 8'h7F;
                got = '0;
                for (int i = 0; i < n; i++) begin
                    get_bit(b);
                    got[i] = b;
                end
                check(got == (e.d & mask), "R2 R3 R10 data bits", got, e.d & mask);
                if (e.pen) begin
                    get_bit(b);
                    check(b == ((^(e.d & mask)) ^ e.podd), "R4 parity bit",
                          b, (^(e.d & mask)) ^ e.podd);
                end
                get_bit(b);
                check(b == 1'b1, "R5 R4 first stop bit", b, 1);
                if (e.two) begin
                    get_bit(b);
                    check(b == 1'b1, "R5 second stop bit", b, 1);
                end
                more_prev = (q.size() > 0);
                idle_cnt = 0;
                frames++;
            end
        end
    end

    task automatic send(input logic [7:0] d, input bit accepted);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (accepted) begin
            e.d = d; e.eight = fmt_eight; e.pen = fmt_par_en;
            e.podd = fmt_par_odd; e.two = fmt_two_stop;
            q.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
        repeat (14 * TICKP) @(negedge clk);
    endtask

    task automatic set_fmt(input bit e8, input bit pe, input bit po, input bit ts);
        @(negedge clk);
        fmt_eight = e8; fmt_par_en = pe; fmt_par_odd = po; fmt_two_stop = ts;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1 reset txd", txd, 1);
        check(fill_count == 0, "R1 reset fill_count", fill_count, 0);
        check(drain_req == 1'b1, "R1 reset drain_req", drain_req, 1);
        check(overflow == 1'b0, "R1 reset overflow", overflow, 0);
        rst_n = 1'b1;
        repeat (3 * TICKP) @(negedge clk);
        check(txd == 1'b1, "R1 idle line after reset", txd, 1);

        // 8N1
        set_fmt(1, 0, 0, 0);
        send(8'hA5, 1); send(8'h3C, 1); send(8'h01, 1);
        wait_drain();
        // 7E1: bit 7 must be dropped
        set_fmt(0, 1, 0, 0);
        send(8'hFF, 1); send(8'h80, 1); send(8'h55, 1);
        wait_drain();
        // 8O2
        set_fmt(1, 1, 1, 1);
        send(8'h00, 1); send(8'hFE, 1);
        wait_drain();
        // 7O2 and 8E1
        set_fmt(0, 1, 1, 1);
        send(8'hC3, 1);
        wait_drain();
        set_fmt(1, 1, 0, 0);
        send(8'h81, 1); send(8'h7F, 1);
        wait_drain();
        // 7N2
        set_fmt(0, 0, 0, 1);
        send(8'hAA, 1);
        wait_drain();
        check(frames == 12, "R10 frame count after format sweep", frames, 12);

        // occupancy while clear-to-send is held off
        set_fmt(1, 0, 0, 0);
        cts_n = 1'b1;
        send(8'h12, 1); send(8'h34, 1); send(8'h56, 1);
        @(negedge clk);
        check(fill_count == 3, "R7 fill_count with three held", fill_count, 3);
        check(drain_req == 1'b0, "R7 drain_req low when not empty", drain_req, 0);
        repeat (4 * TICKP) @(negedge clk);
        check(txd == 1'b1, "R6 no launch while cts_n high", txd, 1);
        check(fill_count == 3, "R6 nothing taken while cts_n high", fill_count, 3);
        cts_n = 1'b0;
        wait_drain();
        check(fill_count == 0, "R7 fill_count after drain", fill_count, 0);
        check(drain_req == 1'b1, "R7 drain_req after drain", drain_req, 1);

        // clear-to-send raised mid-frame
        f0 = frames;
        send(8'h11, 1); send(8'h22, 1);
        while (txd !== 1'b0) @(negedge clk);
        cts_n = 1'b1;
        repeat (20 * TICKP) @(negedge clk);
        check(frames == f0 + 1, "R6 frame in progress completes", frames, f0 + 1);
        check(fill_count == 1, "R6 next frame held", fill_count, 1);
        check(txd == 1'b1, "R6 line idle while held", txd, 1);
        cts_n = 1'b0;
        wait_drain();
        check(frames == f0 + 2, "R6 held frame sent after release", frames, f0 + 2);

        // overflow burst with back-to-back check
        set_fmt(1, 1, 0, 1);
        cts_n = 1'b1;
        for (int i = 0; i < 16; i++) send(8'(i * 17 + 3), 1);
        send(8'hEE, 0);
        @(negedge clk);
        check(fill_count == 16, "R8 fill_count stays at depth", fill_count, 16);
        check(overflow == 1'b1, "R8 overflow set", overflow, 1);
        f0 = frames;
        gap_check_en = 1;
        cts_n = 1'b0;
        wait_drain();
        gap_check_en = 0;
        check(frames == f0 + 16, "R8 R10 dropped byte not sent", frames, f0 + 16);
        check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
        check(drain_req == 1'b1, "R7 drain_req after burst", drain_req, 1);
        check(q.size() == 0, "R10 scoreboard empty", q.size(), 0);
        finish_run();
    end

endmodule